// File: doc/BRIEF.md
# Machine Check Request Controller

This block collects nonrecoverable error pulses from several internal sources and turns them into a single machine check request level for a processor core. Each source has its own report enable. A global enable sits above all of the source enables. When a reported error arrives, the request rises on the next clock edge and stays high.

The request falls only when the processor acknowledges the exception. The block watches processor read strobes for that acknowledge. A read that lands in one of two 8-byte exception vector windows counts as the acknowledge. One window is low in the address space and one is high. When the boot ROM lives behind a remote bus, the high window no longer counts as an acknowledge, and only a read in the low window releases the request.

Every error pulse is also kept in a sticky per-source flag. Software reads these flags and clears them by writing ones.

Top module: `mck_req_ctrl`

## Requirements
- R1: While `glb_en_i` is 0, no error pulse raises `mcreq_o`.
- R2: A pulse on `err_i[k]` raises the request only when `src_en_i[k]` is 1.
- R3: A pulse on `err_i[k]` that is both enabled and globally enabled sets `mcreq_o` on the next rising clock edge. This holds in any cycle.
- R4: Once set, `mcreq_o` stays 1 through idle cycles and through reads outside both windows. It also stays 1 while `rd_vld_i` is 0, whatever `rd_addr_i` holds.
- R5: A read (`rd_vld_i`=1) whose address lies in 0x0000_0200..0x0000_0207 clears `mcreq_o` on the next edge. The neighbours 0x0000_01FF and 0x0000_0208 do not clear it.
- R6: With `rom_remote_i`=0, a read in 0xFFF0_0200..0xFFF0_0207 clears `mcreq_o` on the next edge.
- R7: With `rom_remote_i`=1, a read in the high window leaves `mcreq_o` set. A read in the low window still clears it.
- R8: If a qualifying error arrives in the same cycle as an acknowledge read, `mcreq_o` is 1 after that edge.
- R9: `flags_o[k]` becomes 1 on the edge after any pulse on `err_i[k]`, regardless of the enables. A 1 on `flag_clr_i[k]` clears the flag. A new pulse wins over a clear in the same cycle.
- R10: While the synchronous active-low `rst_n` is 0, `mcreq_o` and all `flags_o` bits become 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_i | input | NUM_SRC | Error pulses, one bit per source |
| src_en_i | input | NUM_SRC | Report enable per source |
| glb_en_i | input | 1 | Global machine check enable |
| rom_remote_i | input | 1 | Boot ROM is remote; high window is not an acknowledge |
| rd_vld_i | input | 1 | Processor read strobe |
| rd_addr_i | input | ADDR_W | Processor read address |
| flag_clr_i | input | NUM_SRC | Write-one-to-clear for the sticky flags |
| flags_o | output | NUM_SRC | Sticky per-source error flags |
| mcreq_o | output | 1 | Machine check request level |

## Verification
The assertions check the following on every cycle:
- The request cannot rise while the global enable is off.
- A qualifying error always sets the request, even when it coincides with an acknowledge.
- The request holds when no read is present and in remote mode when no low-window read occurs.
- A lone low-window read clears the request.
- Every error pulse lands in its flag.
- Reset empties the request and the flags.

The exact window edges and the high-window acknowledge in local mode are shown only by the bench's directed scenarios. The same goes for set-over-clear priority on the flags and a reset issued mid-run.

// File: rtl/mck_pkg.sv
package mck_pkg;
    // Width of each exception vector window, in address bits
    localparam int unsigned WIN_LG = 3;

    // Which window a read falls into
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_LOW  = 2'd1,
        HIT_HIGH = 2'd2
    } win_hit_e;
endpackage

// File: rtl/mck_ack_decode.sv
module mck_ack_decode
    import mck_pkg::*;
#(
    parameter int unsigned     ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 'h0000_0200,
    parameter logic [ADDR_W-1:0] HI_BASE = 'hFFF0_0200
) (
    input  logic              rd_vld_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output win_hit_e          hit_o
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'((1 << WIN_LG) - 1);

    logic in_lo;
    logic in_hi;

    always_comb begin
        in_lo = (rd_addr_i >= LO_BASE) && (rd_addr_i <= LO_BASE + SPAN);
        in_hi = (rd_addr_i >= HI_BASE) && (rd_addr_i <= HI_BASE + SPAN);
        hit_o = HIT_NONE;
        if (rd_vld_i) begin
            if (in_lo) begin
                hit_o = HIT_LOW;
            end else if (in_hi) begin
                hit_o = HIT_HIGH;
            end
        end
    end
endmodule

// File: rtl/mck_src_qual.sv
module mck_src_qual #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] err_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               glb_en_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic [NUM_SRC-1:0] flags_q_i,
    output logic [NUM_SRC-1:0] flags_d_o,
    output logic               raise_o
);
    logic [NUM_SRC-1:0] report;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        always_comb begin
            report[k] = err_i[k] & src_en_i[k];
            // A new pulse takes priority over a clear in the same cycle
            flags_d_o[k] = err_i[k] | (flags_q_i[k] & ~flag_clr_i[k]);
        end
    end

    assign raise_o = glb_en_i & (|report);
endmodule

// File: rtl/mck_req_ctrl.sv
module mck_req_ctrl
    import mck_pkg::*;
#(
    parameter int unsigned       NUM_SRC = 4,
    parameter int unsigned       ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 'h0000_0200,
    parameter logic [ADDR_W-1:0] HI_BASE = 'hFFF0_0200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               glb_en_i,
    input  logic               rom_remote_i,
    input  logic               rd_vld_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               mcreq_o
);
    typedef struct packed {
        logic               req;
        logic [NUM_SRC-1:0] flags;
    } state_t;

    state_t             st_d;
    state_t             st_q;
    win_hit_e           hit;
    logic               raise;
    logic [NUM_SRC-1:0] flags_nx;
    logic               ack;

    mck_ack_decode #(
        .ADDR_W (ADDR_W),
        .LO_BASE(LO_BASE),
        .HI_BASE(HI_BASE)
    ) u_dec (
        .rd_vld_i (rd_vld_i),
        .rd_addr_i(rd_addr_i),
        .hit_o    (hit)
    );

    mck_src_qual #(
        .NUM_SRC(NUM_SRC)
    ) u_qual (
        .err_i     (err_i),
        .src_en_i  (src_en_i),
        .glb_en_i  (glb_en_i),
        .flag_clr_i(flag_clr_i),
        .flags_q_i (st_q.flags),
        .flags_d_o (flags_nx),
        .raise_o   (raise)
    );

    always_comb begin
        ack = (hit == HIT_LOW) || ((hit == HIT_HIGH) && !rom_remote_i);
        st_d = st_q;
        st_d.flags = flags_nx;
        // Raise dominates acknowledge so a coinciding error is not lost
        st_d.req = raise | (st_q.req & ~ack);
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mcreq_o = st_q.req;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/mck_req_ctrl_chk.sv
module mck_req_ctrl_chk #(
    parameter int unsigned       NUM_SRC = 4,
    parameter int unsigned       ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 'h0000_0200
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] err_i,
    input logic [NUM_SRC-1:0] src_en_i,
    input logic               glb_en_i,
    input logic               rom_remote_i,
    input logic               rd_vld_i,
    input logic [ADDR_W-1:0]  rd_addr_i,
    input logic [NUM_SRC-1:0] flags_o,
    input logic               mcreq_o
);
    logic qual;
    logic lo_rd;

    assign qual  = glb_en_i && ((err_i & src_en_i) != '0);
    assign lo_rd = rd_vld_i && (rd_addr_i >= LO_BASE) && (rd_addr_i <= LO_BASE + ADDR_W'(7));

    // R1
    a_r1_glb_off_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i && !mcreq_o) |=> !mcreq_o);

    // R3, R8
    a_r3_raise_next: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> mcreq_o);

    // R4
    a_r4_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mcreq_o && !rd_vld_i) |=> mcreq_o);

    // R5
    a_r5_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mcreq_o && lo_rd && !qual) |=> !mcreq_o);

    // R7
    a_r7_remote_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mcreq_o && rom_remote_i && !lo_rd) |=> mcreq_o);

    // R9
    a_r9_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i != '0) |=> ((flags_o & $past(err_i)) == $past(err_i)));

    // R10
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!mcreq_o && (flags_o == '0)));
endmodule

bind mck_req_ctrl mck_req_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .LO_BASE(LO_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_i       (err_i),
    .src_en_i    (src_en_i),
    .glb_en_i    (glb_en_i),
    .rom_remote_i(rom_remote_i),
    .rd_vld_i    (rd_vld_i),
    .rd_addr_i   (rd_addr_i),
    .flags_o     (flags_o),
    .mcreq_o     (mcreq_o)
);

// File: tb/mck_req_ctrl_bench.sv
module mck_req_ctrl_bench;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] err_i, src_en_i, flag_clr_i;
    logic          glb_en_i, rom_remote_i, rd_vld_i;
    logic [31:0]   rd_addr_i;
    logic [NS-1:0] flags_o;
    logic          mcreq_o;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;
    bit  m_req;
    bit  m_flags [NS];

    always #5 clk = ~clk;

    mck_req_ctrl #(.NUM_SRC(NS)) u_mck_req_ctrl (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .src_en_i(src_en_i),
        .glb_en_i(glb_en_i), .rom_remote_i(rom_remote_i), .rd_vld_i(rd_vld_i),
        .rd_addr_i(rd_addr_i), .flag_clr_i(flag_clr_i), .flags_o(flags_o),
        .mcreq_o(mcreq_o)
    );

    function automatic bit in_win(input logic [31:0] a, input longint base);
        return (longint'(a) >= base) && (longint'(a) < base + 8);
    endfunction

    // One clock: advance the behavioural model, let the edge pass, compare at negedge
    task automatic cycle(input string tag);
        bit nreq;
        bit any_rep = 0;
        bit ackr;
        int got;
        int exp;
        for (int k = 0; k < NS; k++) begin
            if (err_i[k] && src_en_i[k]) any_rep = 1;
        end
        ackr = rd_vld_i && (in_win(rd_addr_i, 64'h200) ||
               (!rom_remote_i && in_win(rd_addr_i, 64'hFFF0_0200)));
        if (!rst_n) begin
            nreq = 0;
            for (int k = 0; k < NS; k++) m_flags[k] = 0;
        end else begin
            if (glb_en_i && any_rep) nreq = 1;
            else if (ackr)           nreq = 0;
            else                     nreq = m_req;
            for (int k = 0; k < NS; k++) begin
                if (err_i[k])           m_flags[k] = 1;
                else if (flag_clr_i[k]) m_flags[k] = 0;
            end
        end
        m_req = nreq;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (mcreq_o !== m_req) begin
            errors++;
            $display("FAIL %s mcreq_o actual=%0b expected=%0b", tag, mcreq_o, m_req);
        end
        got = 0;
        exp = 0;
        for (int k = 0; k < NS; k++) begin
            got += int'(flags_o[k]) << k;
            exp += int'(m_flags[k]) << k;
        end
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL R9 flags_o actual=%0h expected=%0h (%s)", got, exp, tag);
        end
    endtask

    task automatic idle();
        err_i = '0;
        flag_clr_i = '0;
        rd_vld_i = 0;
        rd_addr_i = '0;
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        rd_vld_i = 1;
        rd_addr_i = a;
        cycle(tag);
        idle();
    endtask

    task automatic pulse(input logic [NS-1:0] e, input string tag);
        err_i = e;
        cycle(tag);
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle();
        src_en_i = '0;
        glb_en_i = 0;
        rom_remote_i = 0;
        m_req = 0;
        for (int k = 0; k < NS; k++) m_flags[k] = 0;
        @(negedge clk);
        err_i = 4'hF;                            // R10: reset overrides errors
        cycle("R10");
        cycle("R10");
        idle();
        rst_n = 1;
        cycle("R10");

        src_en_i = 4'hF;                         // R1
        pulse(4'b0010, "R1");
        cycle("R1");

        glb_en_i = 1;                            // R2
        src_en_i = 4'b1101;
        pulse(4'b0010, "R2");
        flag_clr_i = 4'hF;
        cycle("R9");

        pulse(4'b0100, "R3");                    // R3
        cycle("R4");
        cycle("R4");
        rd(32'h0000_0208, "R5");                 // R4 / R5 boundaries
        rd(32'h0000_01FF, "R5");
        rd(32'hFFF0_0208, "R4");
        rd_addr_i = 32'h0000_0200;               // R4: address without strobe
        cycle("R4");
        rd(32'h0000_0207, "R5");

        pulse(4'b0001, "R3");                    // R6
        rd(32'hFFF0_0203, "R6");
        pulse(4'b1000, "R3");
        rd(32'hFFF0_0200, "R6");

        rom_remote_i = 1;                        // R7
        pulse(4'b0001, "R3");
        rd(32'hFFF0_0200, "R7");
        rd(32'hFFF0_0207, "R7");
        rd(32'h0000_0204, "R7");
        rom_remote_i = 0;

        pulse(4'b0100, "R3");                    // R8
        err_i = 4'b0001;
        rd(32'h0000_0200, "R8");
        cycle("R8");
        err_i = 4'b0010;                         // R8 with disabled source: ack wins
        rd(32'h0000_0200, "R8");

        err_i = 4'b0101;                         // R9: set beats clear
        flag_clr_i = 4'b0111;
        cycle("R9");
        idle();
        flag_clr_i = 4'b0100;
        cycle("R9");
        idle();

        pulse(4'b1000, "R3");                    // R10 mid-run
        rst_n = 0;
        cycle("R10");
        rst_n = 1;

        for (int i = 0; i < 400; i++) begin      // mixed traffic
            err_i        = ($urandom % 6 == 0) ? NS'($urandom) : '0;
            src_en_i     = NS'($urandom);
            glb_en_i     = ($urandom % 4) != 0;
            rom_remote_i = ($urandom % 3) == 0;
            flag_clr_i   = ($urandom % 5 == 0) ? NS'($urandom) : '0;
            rd_vld_i     = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: rd_addr_i = 32'h0000_01FC + ($urandom % 16);
                1: rd_addr_i = 32'hFFF0_01FC + ($urandom % 16);
                default: rd_addr_i = $urandom;
            endcase
            cycle("R4");
        end
        idle();
        cycle("R4");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule